// File: doc/BRIEF.md
# Bounded-Burst Block Read Sequencer

This block is a read-only bus master. It pulls a long run of 32-bit words from host memory into a local buffer as a series of bursts whose length can be set to match the host's cache line. One pulse on `start_i` latches the starting byte address, the word count for the whole transfer (13 bits, up to 8191 words) and a burst-size code. The sequencer then repeats the same loop: request the bus, wait for grant, present the address, and collect words until the burst limit or the end of the transfer.

Two independent down-counters drive the loop. The wide one holds the words left in the whole transfer. The narrow one is reloaded before each burst with the smaller of the burst limit and the words still owed, so the last burst may be short. Each accepted word is followed by a forced idle cycle in which the word is written into the local buffer. This gives a slow buffer, which later drains to a narrow serial link, a full cycle to absorb each write. No new burst is requested while the buffer reports almost-full.

Top module: `bsq_burst_reader`

## Requirements
- R1: While `rst_ni` is low and after it rises, `req_o`, `addr_valid_o`, `rd_ready_o`, `wr_en_o`, `done_o` and `busy_o` are 0 until a start is taken.
- R2: A `start_i` pulse while idle with a nonzero word count raises `busy_o`, and raises `req_o` in the next cycle when `buf_afull_i` is low.
- R3: `burst_sel_i` sets the burst limit: 0 gives 4 words, 1 gives 8, and 2 or 3 give 16. Every burst except the last carries exactly that many words.
- R4: `addr_valid_o` is high for exactly the cycle after a cycle with `req_o` and `gnt_i` both high. `addr_o` then equals the start address plus 4 times the words already received, so the address advances by 4 bytes per accepted word across bursts.
- R5: A word is accepted in a cycle with `rd_ready_o` and `rd_valid_i` both high. In the next cycle `rd_ready_o` is 0, `wr_en_o` is 1 and `wr_data_o` holds the accepted word.
- R6: The number of words written equals the programmed count. `done_o` is high for exactly one cycle, two cycles after the last word is accepted, and `busy_o` then falls.
- R7: When the words still owed are fewer than the burst limit, the final burst carries only those words.
- R8: `req_o` is 0 in every cycle in which `buf_afull_i` is 1, and a grant seen in such a cycle starts no burst.
- R9: A start with a word count of 0 gives a `done_o` pulse in the next cycle without raising `req_o`.
- R10: `start_i` is ignored while `busy_o` is high. The running transfer keeps its count, its addresses and its data.
- R11: `rd_valid_i` outside a cycle with `rd_ready_o` high causes no write and consumes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| base_addr_i | input | 32 | Byte address of the first word |
| total_words_i | input | 13 | Words in the whole transfer |
| burst_sel_i | input | 2 | Burst limit code (0:4, 1:8, 2/3:16) |
| buf_afull_i | input | 1 | Local buffer almost full |
| req_o | output | 1 | Bus request |
| gnt_i | input | 1 | Bus grant |
| addr_valid_o | output | 1 | Address phase of a burst |
| addr_o | output | 32 | Current read address |
| rd_valid_i | input | 1 | Read data valid from host |
| rd_data_i | input | 32 | Read data from host |
| rd_ready_o | output | 1 | Sequencer can take a word this cycle |
| wr_en_o | output | 1 | Local buffer write strobe |
| wr_data_o | output | 32 | Local buffer write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench samples every output at the falling edge and predicts each result by the cycle in which it is due. The buffer write and the dropped ready are due one cycle after the accepting edge. The address phase is due one cycle after the edge on which a grant is taken. The done pulse is due two cycles after the last accept. The request is due one cycle after start, and a zero-count done is due one cycle after start. Each expectation is armed at the falling edge before the deciding rising edge and checked at the next falling edge. Any write, address phase or done outside its due cycle counts as a failure. Burst sizes are totalled between address phases and compared with the smaller of the limit and the words still owed.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  localparam int unsigned MAX_BURST_LEN = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_WAIT,
    S_DONE
  } bsq_state_e;

  // burst code -> word limit (3 aliases the largest)
  function automatic logic [4:0] burst_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    burst_limit = 5'd4;
      2'd1:    burst_limit = 5'd8;
      default: burst_limit = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/bsq_down_ctr.sv
module bsq_down_ctr #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned STEP_B  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
    end else if (adv_i) begin
      addr_q <= addr_q + ADDR_W'(STEP_B);
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/bsq_burst_reader.sv
module bsq_burst_reader
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned TOTAL_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  base_addr_i,
  input  logic [TOTAL_W-1:0] total_words_i,
  input  logic [1:0]         burst_sel_i,
  input  logic               buf_afull_i,
  output logic               req_o,
  input  logic               gnt_i,
  output logic               addr_valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  input  logic               rd_valid_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               rd_ready_o,
  output logic               wr_en_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int unsigned BURST_W = $clog2(MAX_BURST_LEN + 1);
  localparam int unsigned STEP_B  = DATA_W / 8;

  bsq_state_e         state_q, state_d;
  logic [BURST_W-1:0] burst_lim_q;
  logic [BURST_W-1:0] burst_load;
  logic [TOTAL_W-1:0] total_cnt;
  logic [BURST_W-1:0] burst_cnt;
  logic               total_zero, burst_zero;
  logic [DATA_W-1:0]  data_q;
  logic               take_start, accept;

  assign take_start = (state_q == S_IDLE) && start_i;
  assign accept     = (state_q == S_DATA) && rd_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = (total_words_i == '0) ? S_DONE : S_REQ;
      S_REQ:  if (gnt_i && !buf_afull_i) state_d = S_ADDR;
      S_ADDR: state_d = S_DATA;
      S_DATA: if (rd_valid_i) state_d = S_WAIT;
      S_WAIT: begin
        if (total_zero)      state_d = S_DONE;
        else if (burst_zero) state_d = S_REQ;
        else                 state_d = S_DATA;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      burst_lim_q <= '0;
      data_q      <= '0;
    end else begin
      state_q <= state_d;
      if (take_start) burst_lim_q <= BURST_W'(burst_limit(burst_sel_i));
      if (accept)     data_q      <= rd_data_i;
    end
  end

  // short last burst: load what is left when below the limit
  always_comb begin
    if (total_cnt < TOTAL_W'(burst_lim_q)) burst_load = total_cnt[BURST_W-1:0];
    else                                   burst_load = burst_lim_q;
  end

  bsq_down_ctr #(.W(TOTAL_W)) u_total_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (take_start),
    .load_val_i (total_words_i),
    .dec_i      (accept),
    .cnt_o      (total_cnt),
    .zero_o     (total_zero)
  );

  bsq_down_ctr #(.W(BURST_W)) u_burst_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (state_q == S_ADDR),
    .load_val_i (burst_load),
    .dec_i      (accept),
    .cnt_o      (burst_cnt),
    .zero_o     (burst_zero)
  );

  bsq_addr_gen #(.ADDR_W(ADDR_W), .STEP_B(STEP_B)) u_addr_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take_start),
    .base_i (base_addr_i),
    .adv_i  (accept),
    .addr_o (addr_o)
  );

  assign req_o        = (state_q == S_REQ) && !buf_afull_i;
  assign addr_valid_o = (state_q == S_ADDR);
  assign rd_ready_o   = (state_q == S_DATA);
  assign wr_en_o      = (state_q == S_WAIT);
  assign wr_data_o    = data_q;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);

endmodule

// File: rtl/bsq_burst_reader_chk.sv
module bsq_burst_reader_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              buf_afull_i,
  input logic              req_o,
  input logic              gnt_i,
  input logic              addr_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rd_valid_i,
  input logic              rd_ready_o,
  input logic              wr_en_o,
  input logic              done_o
);

  p_no_req_afull_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_afull_i |-> !req_o);

  p_addr_after_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i) |=> addr_valid_o);

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ready_o && rd_valid_i) |=> (addr_o == $past(addr_o) + ADDR_W'(4)));

  p_wait_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ready_o && rd_valid_i) |=> (wr_en_o && !rd_ready_o));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_one_phase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_o, addr_valid_o, rd_ready_o, wr_en_o, done_o}));

endmodule

bind bsq_burst_reader bsq_burst_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .buf_afull_i  (buf_afull_i),
  .req_o        (req_o),
  .gnt_i        (gnt_i),
  .addr_valid_o (addr_valid_o),
  .addr_o       (addr_o),
  .rd_valid_i   (rd_valid_i),
  .rd_ready_o   (rd_ready_o),
  .wr_en_o      (wr_en_o),
  .done_o       (done_o)
);

// File: tb/tb_bsq_burst_reader.sv
`timescale 1ns/1ps
module tb_bsq_burst_reader;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [12:0] total_words_i = '0;
  logic [1:0]  burst_sel_i = '0;
  logic        buf_afull_i = 1'b0;
  logic        req_o;
  logic        gnt_i = 1'b0;
  logic        addr_valid_o;
  logic [31:0] addr_o;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        rd_ready_o;
  logic        wr_en_o;
  logic [31:0] wr_data_o;
  logic        busy_o;
  logic        done_o;

  always #2.5 clk_i = ~clk_i;

  bsq_burst_reader dut (
    .clk_i, .rst_ni, .start_i, .base_addr_i, .total_words_i, .burst_sel_i,
    .buf_afull_i, .req_o, .gnt_i, .addr_valid_o, .addr_o, .rd_valid_i,
    .rd_data_i, .rd_ready_o, .wr_en_o, .wr_data_o, .busy_o, .done_o
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // run configuration and monitor state
  bit          act = 0, run_done = 0, afl_mode = 0, afl_used = 0;
  bit          exp_wr = 0, exp_addr = 0;
  int          total_exp, lim_exp, words, bwords, brem, nbursts;
  int          done_cnt, rq_cnt, gdly, vper, afl_cnt, cyc;
  logic [31:0] base_exp, exp_data, dseq = 32'h1357_9bdf;

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  always @(negedge clk_i) begin
    if (!act) begin
      gnt_i = 1'b0; rd_valid_i = 1'b0; buf_afull_i = 1'b0;
    end else begin
      bit done_now, acc;
      done_now = (done_cnt == 1);
      if (exp_wr) begin
        chk(wr_en_o && !rd_ready_o, "R5", "wait slot write/ready", {wr_en_o, rd_ready_o}, 2'b10);
        chk(wr_data_o == exp_data, "R5", "written word", wr_data_o, exp_data);
      end else if (wr_en_o) begin
        chk(1'b0, "R11", "write without accepted word", 1, 0);
      end
      if (exp_addr) begin
        chk(addr_valid_o, "R4", "address phase after grant", addr_valid_o, 1);
        chk(addr_o == base_exp + 32'(4 * words), "R4", "burst address", addr_o, base_exp + 32'(4 * words));
        if (nbursts > 0)
          chk(bwords == min_i(lim_exp, brem), "R3", "burst length", bwords, min_i(lim_exp, brem));
        nbursts++; brem = total_exp - words; bwords = 0; afl_used = 0;
      end else if (addr_valid_o) begin
        chk(1'b0, "R4", "address phase without grant", 1, 0);
      end
      if (done_now) begin
        chk(done_o, "R6", "done pulse due", done_o, 1);
        chk(words == total_exp, "R6", "word total", words, total_exp);
        chk(bwords == min_i(lim_exp, brem), (brem < lim_exp) ? "R7" : "R3",
            "last burst length", bwords, min_i(lim_exp, brem));
        run_done = 1;
      end else if (done_o) begin
        chk(1'b0, "R6", "done outside due cycle", 1, 0);
      end
      if (buf_afull_i) chk(!req_o, "R8", "request while almost full", req_o, 0);

      if (done_cnt > 0) done_cnt--;
      cyc++;
      rd_valid_i = ((cyc % vper) == 0);
      rd_data_i  = dseq;
      acc = rd_ready_o && rd_valid_i;
      exp_wr = acc;
      if (acc) begin
        exp_data = dseq;
        dseq = {dseq[30:0], dseq[31] ^ dseq[21] ^ dseq[1] ^ dseq[0]};
        words++; bwords++;
        if (words == total_exp) done_cnt = 2;
      end
      if (req_o) rq_cnt++; else rq_cnt = 0;
      if (afl_cnt > 0) afl_cnt--;
      if (afl_mode && req_o && !afl_used) begin afl_cnt = 3; afl_used = 1; end
      buf_afull_i = (afl_cnt > 0);
      gnt_i = req_o && (rq_cnt > gdly);
      exp_addr = gnt_i && !buf_afull_i;
    end
  end

  task automatic run(input int sel, input int total, input int gd, input int vp,
                     input bit afl, input bit stray);
    total_exp = total; lim_exp = (sel == 0) ? 4 : (sel == 1) ? 8 : 16;
    base_exp = 32'h0010_0000 + 32'(total * 64) + 32'(sel * 16);
    words = 0; bwords = 0; brem = total; nbursts = 0; done_cnt = 0; rq_cnt = 0;
    gdly = gd; vper = vp; afl_mode = afl; afl_used = 0; afl_cnt = 0; cyc = 0;
    exp_wr = 0; exp_addr = 0; run_done = 0;
    @(negedge clk_i);
    start_i = 1'b1; base_addr_i = base_exp; total_words_i = 13'(total); burst_sel_i = 2'(sel);
    #1 act = 1;
    @(negedge clk_i);
    start_i = 1'b0;
    #1;
    chk(busy_o, "R2", "busy after start", busy_o, 1);
    if (!afl) chk(req_o, "R2", "request after start", req_o, 1);
    if (stray) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1; base_addr_i = 32'hdead_0000; total_words_i = 13'd7; burst_sel_i = 2'd0;
      @(negedge clk_i);
      start_i = 1'b0;
      #1 chk(busy_o, "R10", "start while busy ignored", busy_o, 1);
    end
    for (int i = 0; i < 60000 && !run_done; i++) @(negedge clk_i);
    if (!run_done) chk(1'b0, "R6", "watchdog: transfer never finished", words, total);
    @(negedge clk_i);
    #1 act = 0;
    chk(!busy_o && !req_o, "R6", "idle after done", {busy_o, req_o}, 0);
  endtask

  initial begin
    int totals [8] = '{1, 3, 4, 5, 9, 16, 17, 40};
    repeat (2) @(negedge clk_i);
    chk({req_o, addr_valid_o, rd_ready_o, wr_en_o, done_o, busy_o} == 0, "R1",
        "outputs in reset", {req_o, addr_valid_o, rd_ready_o, wr_en_o, done_o, busy_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({req_o, addr_valid_o, rd_ready_o, wr_en_o, done_o, busy_o} == 0, "R1",
        "outputs idle after reset", {req_o, addr_valid_o, rd_ready_o, wr_en_o, done_o, busy_o}, 0);

    // R9: zero-length transfer
    @(negedge clk_i);
    start_i = 1'b1; total_words_i = '0; burst_sel_i = 2'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    #1 chk(done_o && !req_o, "R9", "zero count done", {done_o, req_o}, 2'b10);
    @(negedge clk_i);
    #1 chk(!done_o && !busy_o && !req_o, "R9", "zero count back to idle", {done_o, busy_o, req_o}, 0);

    // R3 R7 R8 R11: sweep of burst codes and lengths
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 8; t++) begin
        run(s, totals[t], t % 3, 1 + ((s + t) % 3), totals[t] % 2 == 1, t == 6);
      end
    end
    // R6: full 13-bit count
    run(2, 8191, 0, 1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule